// File: doc/BRIEF.md
# Three-Stage Instruction Pipeline Sequencer

This block steps a stream of 32-bit instruction words through fetch, decode and execute. It drives addresses to an instruction memory whose data returns exactly one cycle after each request. Each word passes through a decode slot and then into an execute slot. Execute is modelled as a busy counter. A small field in each word sets how long the instruction stays in execute, whether it is a branch, whether that branch is taken, and whether it saves a return address.

The sequencer stalls younger words behind a multi-cycle instruction without losing the fetch schedule. A taken branch flushes the words that were fetched behind it and restarts fetching at the branch target. The executing instruction always sees a program-counter value eight bytes past its own address. Each instruction produces one retire pulse carrying its address. A taken branch that saves a return address writes that address one cycle after it executes.

Top module: `pipe_seq`

## Requirements
- R1: While rst_ni is low and right after it rises, execute is empty. The first fetch request goes to address 0 in the cycle after release, the next to address 4 in the following cycle, and the word at address 0 executes in the third cycle (cycle index 2, counted from release).
- R2: Word encoding. Bits [1:0] hold the execute cycle count minus one. Bit 4 marks a branch, bit 5 means taken, bit 6 means save a return address, and bits [31:8] are a signed word offset. The target is own address + 8 + 4*offset. A branch always executes for one cycle, whatever bits [1:0] hold.
- R3: Without branches, each instruction enters execute in the cycle after the previous one's last execute cycle, so single-cycle code completes one per cycle.
- R4: In every execute cycle, exec_pc_o equals the executing instruction's address + 8.
- R5: In the first execute cycle of every instruction, imem_req_o is high and imem_addr_o equals that instruction's address + 8.
- R6: A multi-cycle instruction stays in execute with a steady exec_pc_o, and the next word executes with no bubble once it finishes.
- R7: A taken branch raises flush_o in its execute cycle. Execute is empty for the next two cycles and the target executes in the third. The target is requested in the cycle after the flush, and target + 4 in the cycle after that.
- R8: The two words behind a taken branch never execute and never retire.
- R9: retire_o pulses once per instruction, in its last execute cycle, with retire_addr_o equal to its address.
- R10: One cycle after a taken branch with bit 6 set, link_we_o is high and link_addr_o equals the branch address + 4. A branch that is not taken, or that has bit 6 clear, writes nothing.
- R11: A branch that is not taken acts as a one-cycle instruction and raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_req_o | output | 1 | Instruction fetch request |
| imem_addr_o | output | AW | Fetch byte address |
| imem_rdata_i | input | 32 | Instruction word, valid one cycle after the request |
| exec_valid_o | output | 1 | Execute stage holds an instruction |
| exec_pc_o | output | AW | Program-counter value seen by the executing instruction |
| flush_o | output | 1 | Taken branch resolved this cycle |
| retire_o | output | 1 | Instruction completes this cycle |
| retire_addr_o | output | AW | Address of the completing instruction |
| link_we_o | output | 1 | Return-address write strobe |
| link_addr_o | output | AW | Return address to write |

## Verification
The bench goes after back-to-back taken branches, a branch to its own fall-through address, a backward branch, a multi-cycle instruction directly before a taken branch, and a branch whose cycle-count bits are non-zero. A design that fetched one slot too early or too late would show the wrong address on the first-cycle fetch and the wrong program-counter value. A design that leaked a squashed word into execute would retire an address the model never expects. A design that added a bubble after a multi-cycle instruction, or dropped a held word, would drift against the retire schedule of the model. A return-address write on a not-taken branch with bit 6 set is also covered.

// File: rtl/pipe_seq_pkg.sv
package pipe_seq_pkg;
  localparam int unsigned ILEN    = 32;
  localparam int unsigned CYC_LSB = 0;
  localparam int unsigned CYC_W   = 2;
  localparam int unsigned BR_BIT  = 4;
  localparam int unsigned TK_BIT  = 5;
  localparam int unsigned LNK_BIT = 6;
  localparam int unsigned OFF_LSB = 8;
  localparam int unsigned OFF_W   = ILEN - OFF_LSB;
  localparam int unsigned PC_AHEAD = 8;
  localparam int unsigned STEP     = 4;

  typedef struct packed {
    logic             br;
    logic             tk;
    logic             lnk;
    logic [CYC_W-1:0] extra;
  } ctl_t;
endpackage

// File: rtl/ps_fetch.sv
module ps_fetch #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_en_i,
  input  logic          redir_i,
  input  logic [AW-1:0] redir_addr_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          rsp_v_o,
  output logic [AW-1:0] rsp_addr_o
);
  import pipe_seq_pkg::*;
  localparam logic [AW-1:0] INC = AW'(STEP);

  logic [AW-1:0] fpc_q, rsp_addr_q;
  logic          rsp_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fpc_q      <= '0;
      rsp_v_q    <= 1'b0;
      rsp_addr_q <= '0;
    end else if (redir_i) begin
      // in-flight fall-through fetch is dropped
      fpc_q   <= redir_addr_i;
      rsp_v_q <= 1'b0;
    end else begin
      rsp_v_q <= req_en_i;
      if (req_en_i) begin
        fpc_q      <= fpc_q + INC;
        rsp_addr_q <= fpc_q;
      end
    end
  end

  assign req_o      = req_en_i;
  assign addr_o     = fpc_q;
  assign rsp_v_o    = rsp_v_q;
  assign rsp_addr_o = rsp_addr_q;
endmodule

// File: rtl/ps_ibuf.sv
module ps_ibuf #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          take_i,
  input  logic          in_v_i,
  input  logic [AW-1:0] in_addr_i,
  input  logic [IW-1:0] in_word_i,
  output logic          hd_v_o,
  output logic [AW-1:0] hd_addr_o,
  output logic [IW-1:0] hd_word_o
);
  localparam int unsigned SLOTS = 2;

  logic [SLOTS-1:0]         v_q, v_n;
  logic [SLOTS-1:0][AW-1:0] a_q, a_n;
  logic [SLOTS-1:0][IW-1:0] w_q, w_n;

  always_comb begin
    v_n = v_q;
    a_n = a_q;
    w_n = w_q;
    if (clr_i) begin
      v_n = '0;
    end else if (take_i) begin
      if (v_q[0]) begin
        v_n[0] = v_q[1] | in_v_i;
        a_n[0] = v_q[1] ? a_q[1] : in_addr_i;
        w_n[0] = v_q[1] ? w_q[1] : in_word_i;
        v_n[1] = v_q[1] & in_v_i;
        a_n[1] = in_addr_i;
        w_n[1] = in_word_i;
      end else begin
        v_n = '0;  // incoming word consumed directly
      end
    end else if (!v_q[0]) begin
      v_n[0] = in_v_i;
      a_n[0] = in_addr_i;
      w_n[0] = in_word_i;
    end else if (!v_q[1]) begin
      v_n[1] = in_v_i;
      a_n[1] = in_addr_i;
      w_n[1] = in_word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      a_q <= '0;
      w_q <= '0;
    end else begin
      v_q <= v_n;
      a_q <= a_n;
      w_q <= w_n;
    end
  end

  assign hd_v_o    = v_q[0] | in_v_i;
  assign hd_addr_o = v_q[0] ? a_q[0] : in_addr_i;
  assign hd_word_o = v_q[0] ? w_q[0] : in_word_i;
endmodule

// File: rtl/ps_decode.sv
module ps_decode #(
  parameter int unsigned AW = 32
) (
  input  logic                           [AW-1:0] addr_i,
  input  logic       [pipe_seq_pkg::ILEN-1:0]     word_i,
  output pipe_seq_pkg::ctl_t                      ctl_o,
  output logic                           [AW-1:0] tgt_o
);
  import pipe_seq_pkg::*;
  localparam int unsigned EXT = AW - OFF_W;

  logic [AW-1:0] off_ext;
  logic          rsv_unused;

  assign off_ext = {{EXT{word_i[ILEN-1]}}, word_i[OFF_LSB +: OFF_W]};
  assign tgt_o   = addr_i + AW'(PC_AHEAD) + (off_ext << 2);

  assign ctl_o.br    = word_i[BR_BIT];
  assign ctl_o.tk    = word_i[TK_BIT];
  assign ctl_o.lnk   = word_i[LNK_BIT];
  // branches always take a single execute cycle
  assign ctl_o.extra = word_i[BR_BIT] ? '0 : word_i[CYC_LSB +: CYC_W];

  assign rsv_unused = ^{word_i[OFF_LSB-1:LNK_BIT+1], word_i[BR_BIT-1:CYC_LSB+CYC_W]};
endmodule

// File: rtl/ps_exec.sv
module ps_exec #(
  parameter int unsigned AW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dec_v_i,
  input  logic [AW-1:0]      dec_addr_i,
  input  pipe_seq_pkg::ctl_t dec_ctl_i,
  input  logic [AW-1:0]      dec_tgt_i,
  output logic               accept_o,
  output logic               valid_o,
  output logic               first_o,
  output logic               last_o,
  output logic [AW-1:0]      addr_o,
  output logic               flush_o,
  output logic [AW-1:0]      tgt_o,
  output logic               link_we_o,
  output logic [AW-1:0]      link_addr_o
);
  import pipe_seq_pkg::*;

  logic             v_q, first_q, br_q, tk_q, lnk_q, lwe_q;
  logic [CYC_W-1:0] rem_q;
  logic [AW-1:0]    addr_q, tgt_q, ladr_q;
  logic             done;

  assign done     = (rem_q == '0);
  assign accept_o = !v_q || done;
  assign flush_o  = v_q && br_q && tk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q     <= 1'b0;
      first_q <= 1'b0;
      br_q    <= 1'b0;
      tk_q    <= 1'b0;
      lnk_q   <= 1'b0;
      rem_q   <= '0;
      addr_q  <= '0;
      tgt_q   <= '0;
    end else if (accept_o) begin
      v_q     <= dec_v_i && !flush_o;
      first_q <= dec_v_i && !flush_o;
      br_q    <= dec_ctl_i.br;
      tk_q    <= dec_ctl_i.tk;
      lnk_q   <= dec_ctl_i.lnk;
      rem_q   <= dec_ctl_i.extra;
      addr_q  <= dec_addr_i;
      tgt_q   <= dec_tgt_i;
    end else begin
      rem_q   <= rem_q - 1'b1;
      first_q <= 1'b0;
    end
  end

  // return address written one cycle late, already pointing past the branch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lwe_q  <= 1'b0;
      ladr_q <= '0;
    end else begin
      lwe_q  <= flush_o && lnk_q;
      ladr_q <= addr_q + AW'(STEP);
    end
  end

  assign valid_o     = v_q;
  assign first_o     = v_q && first_q;
  assign last_o      = v_q && done;
  assign addr_o      = addr_q;
  assign tgt_o       = tgt_q;
  assign link_we_o   = lwe_q;
  assign link_addr_o = ladr_q;
endmodule

// File: rtl/pipe_seq.sv
module pipe_seq #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          imem_req_o,
  output logic [AW-1:0] imem_addr_o,
  input  logic [31:0]   imem_rdata_i,
  output logic          exec_valid_o,
  output logic [AW-1:0] exec_pc_o,
  output logic          flush_o,
  output logic          retire_o,
  output logic [AW-1:0] retire_addr_o,
  output logic          link_we_o,
  output logic [AW-1:0] link_addr_o
);
  import pipe_seq_pkg::*;

  logic          req_en, rsp_v, hd_v, accept, ex_v, ex_first, ex_last, flush, take;
  logic [AW-1:0] rsp_addr, hd_addr, dec_tgt, ex_addr, ex_tgt;
  logic [ILEN-1:0] hd_word;
  ctl_t          dec_ctl;

  // fetch only while execute is empty or an instruction starts execute
  assign req_en = !ex_v || ex_first;
  assign take   = hd_v && accept && !flush;

  ps_fetch #(.AW(AW)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_en_i     (req_en),
    .redir_i      (flush),
    .redir_addr_i (ex_tgt),
    .req_o        (imem_req_o),
    .addr_o       (imem_addr_o),
    .rsp_v_o      (rsp_v),
    .rsp_addr_o   (rsp_addr)
  );

  ps_ibuf #(.AW(AW), .IW(ILEN)) u_ibuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (flush),
    .take_i    (take),
    .in_v_i    (rsp_v),
    .in_addr_i (rsp_addr),
    .in_word_i (imem_rdata_i),
    .hd_v_o    (hd_v),
    .hd_addr_o (hd_addr),
    .hd_word_o (hd_word)
  );

  ps_decode #(.AW(AW)) u_dec (
    .addr_i (hd_addr),
    .word_i (hd_word),
    .ctl_o  (dec_ctl),
    .tgt_o  (dec_tgt)
  );

  ps_exec #(.AW(AW)) u_exec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dec_v_i     (hd_v),
    .dec_addr_i  (hd_addr),
    .dec_ctl_i   (dec_ctl),
    .dec_tgt_i   (dec_tgt),
    .accept_o    (accept),
    .valid_o     (ex_v),
    .first_o     (ex_first),
    .last_o      (ex_last),
    .addr_o      (ex_addr),
    .flush_o     (flush),
    .tgt_o       (ex_tgt),
    .link_we_o   (link_we_o),
    .link_addr_o (link_addr_o)
  );

  assign exec_valid_o  = ex_v;
  assign exec_pc_o     = ex_addr + AW'(PC_AHEAD);
  assign flush_o       = flush;
  assign retire_o      = ex_last;
  assign retire_addr_o = ex_addr;
endmodule

// File: rtl/pipe_seq_chk.sv
module pipe_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          imem_req_o,
  input logic          exec_valid_o,
  input logic [AW-1:0] exec_pc_o,
  input logic          flush_o,
  input logic          retire_o,
  input logic          link_we_o
);
  // R7
  flush_gap1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !exec_valid_o);
  // R7
  flush_gap2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> ##1 !exec_valid_o);
  // R7
  refill_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> imem_req_o);
  // R10
  link_after_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> $past(flush_o));
  // R6
  multi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && !retire_o) |=> (exec_valid_o && $stable(exec_pc_o)));
  // R9
  retire_in_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |-> exec_valid_o);
  // R2
  branch_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> retire_o);
endmodule

bind pipe_seq pipe_seq_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .imem_req_o   (imem_req_o),
  .exec_valid_o (exec_valid_o),
  .exec_pc_o    (exec_pc_o),
  .flush_o      (flush_o),
  .retire_o     (retire_o),
  .link_we_o    (link_we_o)
);

// File: tb/sim_pipe_seq.sv
`timescale 1ns/1ps
module sim_pipe_seq;
  localparam int AW   = 32;
  localparam int NCYC = 400;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          imem_req_o;
  logic [AW-1:0] imem_addr_o;
  logic [31:0]   imem_rdata_i = '0;
  logic          exec_valid_o, flush_o, retire_o, link_we_o;
  logic [AW-1:0] exec_pc_o, retire_addr_o, link_addr_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pipe_seq #(.AW(AW)) u0 (
    .clk_i (clk), .rst_ni (rst_ni),
    .imem_req_o (imem_req_o), .imem_addr_o (imem_addr_o), .imem_rdata_i (imem_rdata_i),
    .exec_valid_o (exec_valid_o), .exec_pc_o (exec_pc_o), .flush_o (flush_o),
    .retire_o (retire_o), .retire_addr_o (retire_addr_o),
    .link_we_o (link_we_o), .link_addr_o (link_addr_o)
  );

  // R2 encoding: [1:0] cycles-1, [4] branch, [5] taken, [6] link, [31:8] word offset
  function automatic logic [31:0] enc(int cm1, bit br, bit tk, bit lk, int off);
    return {off[23:0], 1'b0, lk, tk, br, 2'b00, cm1[1:0]};
  endfunction

  function automatic logic [31:0] prog(logic [31:0] a);
    case (a)
      32'h04:  return enc(2, 0, 0, 0, 0);
      32'h08:  return enc(3, 0, 0, 0, 0);
      32'h10:  return enc(1, 1, 0, 0, 7);   // not taken, cycle bits set
      32'h14:  return enc(3, 1, 1, 0, 9);   // -> 0x40
      32'h18:  return enc(1, 0, 0, 0, 0);
      32'h1C:  return enc(2, 0, 0, 0, 0);
      32'h40:  return enc(1, 0, 0, 0, 0);
      32'h44:  return enc(0, 1, 1, 1, 5);   // -> 0x60, link
      32'h48:  return enc(3, 0, 0, 0, 0);
      32'h4C:  return enc(3, 0, 0, 0, 0);
      32'h64:  return enc(0, 1, 1, 0, 1);   // -> 0x70
      32'h68:  return enc(2, 0, 0, 0, 0);
      32'h6C:  return enc(2, 0, 0, 0, 0);
      32'h70:  return enc(0, 1, 1, 1, -1);  // -> 0x74 fall-through, link
      32'h74:  return enc(3, 0, 0, 0, 0);
      32'h78:  return enc(0, 1, 1, 1, 32);  // -> 0x100, link
      32'h7C:  return enc(1, 0, 0, 0, 0);
      32'h104: return enc(1, 1, 0, 1, 3);   // not taken, link bit set
      32'h120: return enc(0, 1, 1, 0, -74); // -> 0x000
      default: return 32'h0;
    endcase
  endfunction

  always_ff @(posedge clk) if (imem_req_o) imem_rdata_i <= prog(imem_addr_o);

  bit          e_v[NCYC], e_ret[NCYC], e_fl[NCYC], e_lw[NCYC], e_rq[NCYC];
  logic [31:0] e_pc[NCYC], e_radr[NCYC], e_ladr[NCYC], e_ra[NCYC];

  task automatic build_model();
    logic [31:0] pc, w, tgt;
    int s, n, off;
    pc = 0; s = 2;
    e_rq[0] = 1; e_ra[0] = 32'h0;
    e_rq[1] = 1; e_ra[1] = 32'h4;
    while (s < NCYC) begin
      w = prog(pc);
      n = w[4] ? 1 : int'(w[1:0]) + 1;
      for (int k = 0; k < n; k++)
        if (s + k < NCYC) begin e_v[s+k] = 1; e_pc[s+k] = pc + 8; end
      if (s + n - 1 < NCYC) begin e_ret[s+n-1] = 1; e_radr[s+n-1] = pc; end
      e_rq[s] = 1; e_ra[s] = pc + 8;
      if (w[4] && w[5]) begin
        off = int'($signed(w[31:8]));
        tgt = pc + 8 + 32'(off * 4);
        e_fl[s] = 1;
        if (s + 1 < NCYC) begin
          e_rq[s+1] = 1; e_ra[s+1] = tgt;
          if (w[6]) begin e_lw[s+1] = 1; e_ladr[s+1] = pc + 4; end
        end
        if (s + 2 < NCYC) begin e_rq[s+2] = 1; e_ra[s+2] = tgt + 4; end
        pc = tgt; s = s + 3;
      end else begin
        pc = pc + 4; s = s + n;
      end
    end
  endtask

  task automatic chk(string tag, int cyc, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  initial begin
    build_model();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 exec_valid in reset", -1, 32'(exec_valid_o), 0);
    chk("R1 retire in reset", -1, 32'(retire_o), 0);
    chk("R1 fetch addr in reset", -1, imem_addr_o, 0);
    rst_ni = 1'b1;
    #1;
    for (int c = 0; c < NCYC; c++) begin
      chk("R3 R6 R8 exec_valid", c, 32'(exec_valid_o), 32'(e_v[c]));
      if (e_v[c]) chk("R4 exec_pc", c, exec_pc_o, e_pc[c]);
      chk("R9 R8 retire", c, 32'(retire_o), 32'(e_ret[c]));
      if (e_ret[c]) chk("R9 retire_addr", c, retire_addr_o, e_radr[c]);
      chk("R7 R11 flush", c, 32'(flush_o), 32'(e_fl[c]));
      chk("R10 link_we", c, 32'(link_we_o), 32'(e_lw[c]));
      if (e_lw[c]) chk("R10 link_addr", c, link_addr_o, e_ladr[c]);
      if (e_rq[c]) begin
        chk("R5 R7 R1 fetch req", c, 32'(imem_req_o), 1);
        chk("R5 R7 R1 fetch addr", c, imem_addr_o, e_ra[c]);
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule